// File: doc/BRIEF.md
# Masked Fault Interrupt Pulser

This block gathers a set of fault and status condition lines into one interrupt pin. Each line has a sticky flag, a mask bit and a trigger kind: rising edge only, or both edges. A qualifying edge always sets that line's flag. If the line is unmasked and the block is armed, the edge also queues one active-low pulse on the interrupt pin. The pin is open-drain: `irq_pull` high means the pin is pulled low, and low means the pin is released.

Each pulse lasts a fixed number of tick enables. With a 1 MHz tick and the default count, a pulse is 128 µs long. Events that arrive while a pulse is in progress are counted as pending. They are sent later as back-to-back pulses, each followed by a release time of at least one pulse width.

A host read strobe clears a flag. Lines marked as holding keep their flag through reads while their condition is still present. Pulses are blocked until start-up completes. If start-up ends in a fault, the pin stays quiet until the next reset.

Top module: `fault_irq_pulser`

## Requirements
- R1: After reset, every flag reads 0 and `irq_pull` is 0 (pin released).
- R2: On a rising-type line, a 0-to-1 change of `cond[i]` sets `flags[i]` at the next clock edge. A 1-to-0 change does not set it.
- R3: Lines whose bit is set in `BOTH_EDGE` (by default line 0, the input power-good line) set their flag on both the rising and the falling change.
- R4: Once the block is armed, an unmasked qualifying edge raises `irq_pull` for exactly `PULSE_TICKS` tick enables. The pulse begins one clock edge after the edge that sets the flag.
- R5: An edge on a line whose `mask[i]` is 1 still sets the flag, but it produces no pulse.
- R6: Clearing a mask bit while its condition is already high produces no pulse. The next qualifying edge after unmasking does produce one.
- R7: A read strobe `rd_clr[i]` clears `flags[i]`. For lines whose bit is set in `HOLD_MASK` (by default line 1, input over-voltage), the read is ignored while `cond[i]` is 1. The first read after the condition drops clears the flag.
- R8: A line not in `HOLD_MASK` clears on a read even while its condition is still 1.
- R9: A qualifying edge in the same cycle as a read of that line leaves the flag set.
- R10: Before `boot_done` first rises, no pulse is sent. Events from that period are not queued for later.
- R11: If `boot_fault` is 1 in the cycle where `boot_done` is first seen high, no pulse is sent until the next reset. Flags still work.
- R12: Several events, whether in one cycle or during a pulse, each give their own pulse. Between pulses the pin is released for at least `PULSE_TICKS` tick enables.
- R13: Pulse length counts `tick` enables, not clock cycles, so a slower tick stretches the pulse in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one cycle per tick |
| boot_done | input | 1 | Start-up has completed |
| boot_fault | input | 1 | Start-up ended in a fault (sampled when boot_done is first high) |
| cond | input | NSRC | Condition level of each line |
| mask | input | NSRC | 1 blocks pulses from that line |
| rd_clr | input | NSRC | Host read strobe per flag |
| flags | output | NSRC | Sticky flag per line |
| irq_pull | output | 1 | 1 pulls the open-drain interrupt pin low |

## Verification
Several properties are checked on every cycle:
- a rising condition sets its flag;
- a holding flag survives while its condition stays high;
- the pin stays released while the block is not armed;
- the pin is released for more than one cycle after every pulse;
- the pin stays released when nothing is pending or firing.

Other behaviour can only be shown by the bench's scenarios. This includes pulse widths in ticks, the order and spacing of queued pulses, the no-pulse-on-unmask rule, the read-versus-set priority, and the lasting effect of a start-up fault.

// File: rtl/fault_irq_pulser.sv
module fault_irq_pulser #(
  parameter int NSRC        = 6,
  parameter logic [NSRC-1:0] BOTH_EDGE = 6'b000001,
  parameter logic [NSRC-1:0] HOLD_MASK = 6'b000010,
  parameter int PULSE_TICKS = 128,
  parameter int PEND_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            boot_done,
  input  logic            boot_fault,
  input  logic [NSRC-1:0] cond,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] rd_clr,
  output logic [NSRC-1:0] flags,
  output logic            irq_pull
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam int SW = PEND_W + 2;
  localparam logic [SW-1:0] PMAX = SW'((1 << PEND_W) - 1);

  typedef enum logic [1:0] {IDLE, LOW, GAP} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [PEND_W-1:0] pending;
  logic [NSRC-1:0] cond_q, ev, fire;
  logic            booted, armed;
  logic            last, start;
  logic [SW-1:0]   nfire, psum;

  assign ev    = (cond & ~cond_q) | (BOTH_EDGE & ~cond & cond_q);
  assign fire  = armed ? (ev & ~mask) : '0;
  assign nfire = SW'($countones(fire));
  assign last  = tick && (cnt == CW'(PULSE_TICKS - 1));
  assign start = (pending != '0) && (st == IDLE || (st == GAP && last));
  assign psum  = SW'(pending) + nfire - SW'(start);
  assign irq_pull = (st == LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      flags  <= '0;
      booted <= 1'b0;
      armed  <= 1'b0;
    end else begin
      cond_q <= cond;
      flags  <= ev | (flags & ~(rd_clr & ~(HOLD_MASK & cond)));
      if (boot_done && !booted) begin
        booted <= 1'b1;
        armed  <= !boot_fault;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      pending <= '0;
    end else begin
      pending <= (psum > PMAX) ? PMAX[PEND_W-1:0] : psum[PEND_W-1:0];
      if (start) begin
        st  <= LOW;
        cnt <= '0;
      end else if (st != IDLE && tick) begin
        if (last) begin
          st  <= (st == LOW) ? GAP : IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_quiet_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq_pull);

  p_release_after_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull) |=> !irq_pull);

  p_nothing_queued_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && pending == '0 && fire == '0) |=> !irq_pull);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    p_rise_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[i] && !cond_q[i]) |=> flags[i]);
    if (HOLD_MASK[i]) begin : g_hold
      p_hold_while_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && cond[i]) |=> flags[i]);
    end
  end
endmodule

// File: tb/test_fault_irq_pulser.sv
module test_fault_irq_pulser;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int PT = 4;

  logic clk = 0, rst_n = 0, tick = 1, boot_done = 0, boot_fault = 0;
  logic [N-1:0] cond = '0, mask = '0, rd_clr = '0;
  logic [N-1:0] flags;
  logic irq_pull;

  int n_chk = 0, n_bad = 0;
  int pulses = 0, w = 0, last_w = 0, hi_run = 0, min_gap = 999;
  bit seen = 0, prev = 0, slow = 0, done = 0;
  int tdiv = 0;

  fault_irq_pulser #(.NSRC(N), .PULSE_TICKS(PT)) i_fault_irq_pulser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .boot_done(boot_done),
    .boot_fault(boot_fault), .cond(cond), .mask(mask), .rd_clr(rd_clr),
    .flags(flags), .irq_pull(irq_pull));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick = slow ? (tdiv == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (irq_pull && !prev) begin
      pulses++;
      if (seen && hi_run < min_gap) min_gap = hi_run;
      w = 1;
    end else if (irq_pull) w++;
    else if (prev) begin last_w = w; seen = 1; hi_run = 1; end
    else hi_run++;
    prev = irq_pull;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon;
    pulses = 0; seen = 0; min_gap = 999;
  endtask

  task automatic rd(input int i);
    rd_clr[i] = 1; step(1); rd_clr[i] = 0;
  endtask

  task automatic do_reset(input bit fault);
    rst_n = 0; boot_done = 0; boot_fault = fault; cond = '0; mask = '0; rd_clr = '0;
    step(3); rst_n = 1; step(1);
  endtask

  task automatic t_reset;
    check(flags == '0, "R1 flags", flags, 0);
    check(irq_pull == 0, "R1 irq", irq_pull, 0);
  endtask

  task automatic t_boot_gate;
    clr_mon();
    cond[2] = 1; step(20);
    check(pulses == 0, "R10 pre-boot pulses", pulses, 0);
    check(flags[2] == 1, "R2 flag set pre-boot", flags[2], 1);
    boot_done = 1; step(20);
    check(pulses == 0, "R10 no late pulse", pulses, 0);
    cond[2] = 0; rd(2); step(1);
  endtask

  task automatic t_single;
    clr_mon();
    cond[3] = 1; step(1);
    check(irq_pull == 0 && flags[3] == 1, "R4 after first edge", irq_pull, 0);
    step(1);
    check(irq_pull == 1, "R4 pulse start", irq_pull, 1);
    step(3 * PT);
    check(pulses == 1 && last_w == PT, "R4 width", last_w, PT);
    rd(3); cond[3] = 0; step(2 * PT);
    check(flags[3] == 0, "R2 fall no flag", flags[3], 0);
    check(pulses == 1, "R2 fall no pulse", pulses, 1);
  endtask

  task automatic t_both;
    clr_mon();
    cond[0] = 1; step(3 * PT);
    check(flags[0] == 1, "R3 rise flag", flags[0], 1);
    rd(0); cond[0] = 0; step(1);
    check(flags[0] == 1, "R3 fall flag", flags[0], 1);
    step(3 * PT);
    check(pulses == 2, "R3 two pulses", pulses, 2);
    rd(0); step(1);
  endtask

  task automatic t_mask;
    clr_mon();
    mask[4] = 1; cond[4] = 1; step(3 * PT);
    check(flags[4] == 1, "R5 masked flag", flags[4], 1);
    check(pulses == 0, "R5 masked no pulse", pulses, 0);
    mask[4] = 0; step(3 * PT);
    check(pulses == 0, "R6 unmask no pulse", pulses, 0);
    cond[4] = 0; step(2); cond[4] = 1; step(3 * PT);
    check(pulses == 1, "R6 new edge pulse", pulses, 1);
    cond[4] = 0; rd(4); step(1);
  endtask

  task automatic t_hold;
    cond[1] = 1; step(3 * PT);
    rd(1); step(1);
    check(flags[1] == 1, "R7 hold while present", flags[1], 1);
    cond[1] = 0; step(2);
    check(flags[1] == 1, "R7 kept after drop", flags[1], 1);
    rd(1); step(1);
    check(flags[1] == 0, "R7 clears after drop", flags[1], 0);
  endtask

  task automatic t_nonhold;
    cond[5] = 1; step(3 * PT);
    rd(5); step(1);
    check(flags[5] == 0, "R8 clears while present", flags[5], 0);
    cond[5] = 0; step(1);
  endtask

  task automatic t_set_vs_read;
    step(3 * PT);
    cond[2] = 1; rd_clr[2] = 1; step(1); rd_clr[2] = 0;
    check(flags[2] == 1, "R9 set wins", flags[2], 1);
    step(3 * PT); cond[2] = 0; rd(2); step(1);
  endtask

  task automatic t_queue;
    clr_mon();
    cond[2] = 1; cond[3] = 1; cond[5] = 1; step(2);
    cond[4] = 1; step(10 * PT);
    check(pulses == 4, "R12 pulse count", pulses, 4);
    check(min_gap >= PT, "R12 gap", min_gap, PT);
    check(last_w == PT, "R12 width", last_w, PT);
    cond = '0; rd_clr = '1; step(1); rd_clr = '0; step(1);
  endtask

  task automatic t_slow;
    clr_mon();
    slow = 1; step(3);
    cond[3] = 1; step(10 * PT);
    check(pulses == 1, "R13 one pulse", pulses, 1);
    check(last_w >= 3 * PT - 2 && last_w <= 3 * PT, "R13 width in ticks", last_w, 3 * PT);
    slow = 0; cond[3] = 0; rd(3); step(2);
  endtask

  task automatic t_boot_fault;
    do_reset(1);
    clr_mon();
    step(2); boot_done = 1; step(2); boot_fault = 0;
    cond[3] = 1; step(4 * PT);
    check(flags[3] == 1, "R11 flag works", flags[3], 1);
    check(pulses == 0, "R11 no pulse", pulses, 0);
    cond[3] = 0; step(2); cond[0] = 1; step(4 * PT);
    check(pulses == 0, "R11 still quiet", pulses, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    do_reset(0);
    t_reset();
    t_boot_gate();
    t_single();
    t_both();
    t_mask();
    t_hold();
    t_nonhold();
    t_set_vs_read();
    t_queue();
    t_slow();
    t_boot_fault();
    finish_run();
  end
endmodule